// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the frame (left/right) clock of one audio serial port, working directly from the master clock that drives it. Two 3-bit codes in a mode word set the frame length: one gives the number of master clocks per frame, the other the number of bit clocks per frame. The bit clock divide ratio is their quotient, always a power of two. Codes that the configured revision does not support, and settings whose quotient is below 2, raise an error flag and keep the generated clocks idle.

Each transfer direction (output or input) chooses on its own whether the port drives the clocks (master) or receives them (slave). In slave mode the received clocks are passed to the outputs, and the dividers are held at phase zero. Four polarity bits invert the frame and bit clocks, with separate bits for master and slave operation. One bit of a shared enable vector gates the port, and the parameter `PORT_IDX` chooses which bit that is.

Top module: `aclk_gen`

## Requirements
- R1: Mode bits 14:12 select the master clocks per frame. Codes 0, 1, 2, 3 give 512, 256, 128, 64. Code 4 gives 32 when REV is 2 or more and is invalid otherwise. Codes 5 to 7 are invalid.
- R2: Mode bits 10:8 select the bit clocks per frame. Codes 0, 1, 2, 3, 4 give 32, 64, 128, 256, 512. Code 7 gives 16 when REV is 2 or more and is invalid otherwise. Codes 5 and 6 are invalid.
- R3: `cfg_err_o` is high, combinationally, whenever either code is invalid or the master clocks per frame are fewer than twice the bit clocks per frame. While it is high the generated clocks stay at their inactive level.
- R4: While running, the generated bit clock has a period of D = (master clocks per frame)/(bits per frame) cycles. It is low for the first D/2 cycles counted from the cycle in which running starts, then high for D/2 cycles.
- R5: While running, the generated frame clock starts low and toggles every B/2 bit clock periods, where B is the bits per frame. Every change of the frame clock coincides with a falling edge of the bit clock.
- R6: When `dir_i` is 0, mode bit 0 puts the port in master mode. When `dir_i` is 1, mode bit 4 does.
- R7: In slave mode, `bclk_o` equals `ext_bclk_i` XOR polarity bit 0, and `fclk_o` equals `ext_fclk_i` XOR polarity bit 4, whatever the enable.
- R8: In master mode, polarity bit 8 inverts `bclk_o` and polarity bit 12 inverts `fclk_o`. The inversion applies to the idle level as well.
- R9: Only bit `4*PORT_IDX` of `clk_en_i` enables the port, and every other bit is ignored. While the port is disabled in master mode, the outputs hold their inactive level, which is 0 XOR the master inversion bit.
- R10: After any time spent disabled, in error or in slave mode, master generation restarts from phase zero, as described in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all dividers count its rising edges |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cfg_i | input | 16 | Ratio codes (14:12, 10:8) and master selects (bit 0 output, bit 4 input) |
| pol_cfg_i | input | 16 | Inversions: 12 frame/master, 8 bit/master, 4 frame/slave, 0 bit/slave |
| clk_en_i | input | 8 | Shared port enable vector; bit 4*PORT_IDX is used |
| dir_i | input | 1 | Active direction: 0 output, 1 input |
| ext_bclk_i | input | 1 | Received bit clock for slave mode |
| ext_fclk_i | input | 1 | Received frame clock for slave mode |
| bclk_o | output | 1 | Bit clock out |
| fclk_o | output | 1 | Frame clock out |
| cfg_err_o | output | 1 | Unsupported or too-small ratio |

## Verification
The frame clock transition and the bit clock falling edge must fall in the same master clock cycle. The bench provokes this coincidence at every frame-half boundary, sweeping all 64 code pairs with the polarity bits varied. It predicts both outputs arithmetically from a cycle count, using modulo and division by D and B. A second coincidence is a stop and the next phase-zero restart: the bench disables the port, or moves it through slave mode, in the middle of a bit period. It then requires idle levels at once and a fresh low half-period when the port runs again.

// File: rtl/aclk_gen_pkg.sv
package aclk_gen_pkg;
  localparam int CODE_W        = 3;
  localparam int LOG_W         = 4;
  localparam int MAX_RATIO_LOG = 5;  // 512 / 16
  localparam int MAX_FRAME_LOG = 9;  // 512 bits per frame
  localparam int RATIO_LOG_W   = $clog2(MAX_RATIO_LOG + 1);

  typedef struct packed {
    logic             ok;
    logic [LOG_W-1:0] lg;
  } log_code_t;

  // master clocks per frame, as log2
  function automatic log_code_t mclk_log(input logic [CODE_W-1:0] code, input int rev);
    log_code_t r;
    r.ok = 1'b1;
    case (code)
      3'd0: r.lg = 4'd9;
      3'd1: r.lg = 4'd8;
      3'd2: r.lg = 4'd7;
      3'd3: r.lg = 4'd6;
      3'd4: begin r.lg = 4'd5; r.ok = (rev >= 2); end
      default: begin r.lg = 4'd0; r.ok = 1'b0; end
    endcase
    return r;
  endfunction

  // bit clocks per frame, as log2
  function automatic log_code_t frame_log(input logic [CODE_W-1:0] code, input int rev);
    log_code_t r;
    r.ok = 1'b1;
    case (code)
      3'd0: r.lg = 4'd5;
      3'd1: r.lg = 4'd6;
      3'd2: r.lg = 4'd7;
      3'd3: r.lg = 4'd8;
      3'd4: r.lg = 4'd9;
      3'd7: begin r.lg = 4'd4; r.ok = (rev >= 2); end
      default: begin r.lg = 4'd0; r.ok = 1'b0; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/aclk_gen_ratio_dec.sv
module aclk_gen_ratio_dec
  import aclk_gen_pkg::*;
#(
  parameter int REV = 2
) (
  input  logic [CODE_W-1:0]      mclk_code_i,
  input  logic [CODE_W-1:0]      frame_code_i,
  output logic                   err_o,
  output logic [RATIO_LOG_W-1:0] ratio_lg_o,
  output logic [LOG_W-1:0]       frame_lg_o
);
  log_code_t m_dec, f_dec;

  always_comb begin
    m_dec = mclk_log(mclk_code_i, REV);
    f_dec = frame_log(frame_code_i, REV);
    // ratio below 2 means mclk log not strictly above frame log
    err_o = !m_dec.ok || !f_dec.ok || (m_dec.lg <= f_dec.lg);
    ratio_lg_o = err_o ? '0 : RATIO_LOG_W'(m_dec.lg - f_dec.lg);
    frame_lg_o = err_o ? '0 : f_dec.lg;
  end

  // R3: a valid setting never yields a ratio beyond the divider range
  always_comb begin
    if (!err_o) begin
      a_r3_ratio_range: assert (ratio_lg_o >= 1 && ratio_lg_o <= RATIO_LOG_W'(MAX_RATIO_LOG));
    end
  end
endmodule

// File: rtl/aclk_gen_div.sv
module aclk_gen_div
  import aclk_gen_pkg::*;
#(
  parameter int DIV_W = MAX_RATIO_LOG,
  parameter int FRM_W = MAX_FRAME_LOG
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_i,
  input  logic [RATIO_LOG_W-1:0] ratio_lg_i,
  input  logic [LOG_W-1:0]       frame_lg_i,
  output logic                   bclk_gen_o,
  output logic                   fclk_gen_o
);
  logic [DIV_W-1:0] div_cnt;
  logic [FRM_W-1:0] bit_cnt;
  logic [DIV_W:0]   div_span;
  logic [FRM_W:0]   frm_span;
  logic [DIV_W-1:0] div_wrap, div_half;
  logic [FRM_W-1:0] frm_wrap, frm_half;
  logic             bit_end;

  always_comb begin
    div_span = (DIV_W+1)'(1) << ratio_lg_i;
    frm_span = (FRM_W+1)'(1) << frame_lg_i;
    div_wrap = DIV_W'(div_span - 1'b1);
    frm_wrap = FRM_W'(frm_span - 1'b1);
    div_half = DIV_W'(1) << (ratio_lg_i - 1'b1);
    frm_half = FRM_W'(1) << (frame_lg_i - 1'b1);
  end

  assign bit_end = (div_cnt == div_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bit_cnt <= '0;
    end else if (!run_i) begin
      div_cnt <= '0;
      bit_cnt <= '0;
    end else begin
      div_cnt <= bit_end ? '0 : div_cnt + 1'b1;
      if (bit_end) bit_cnt <= (bit_cnt == frm_wrap) ? '0 : bit_cnt + 1'b1;
    end
  end

  assign bclk_gen_o = run_i & (|(div_cnt & div_half));
  assign fclk_gen_o = run_i & (|(bit_cnt & frm_half));

  // previous-cycle copies, used only by the checks below
  logic run_q, bclk_q, fclk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
    end else begin
      run_q  <= run_i;
      bclk_q <= bclk_gen_o;
      fclk_q <= fclk_gen_o;
    end
  end

  a_r5_frame_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && run_q && (fclk_gen_o != fclk_q)) |-> (bclk_q && !bclk_gen_o));

  a_r10_phase_zero_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (div_cnt == '0 && bit_cnt == '0));

  a_r4_rise_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run_i && !bclk_q && bclk_gen_o) |-> (div_cnt == div_half));

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (div_cnt <= div_wrap));
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_gen_pkg::*;
#(
  parameter int REV      = 2,
  parameter int PORT_IDX = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] mode_cfg_i,
  input  logic [15:0] pol_cfg_i,
  input  logic [7:0]  clk_en_i,
  input  logic        dir_i,
  input  logic        ext_bclk_i,
  input  logic        ext_fclk_i,
  output logic        bclk_o,
  output logic        fclk_o,
  output logic        cfg_err_o
);
  localparam int EN_BIT = 4 * PORT_IDX;

  logic                   port_en, master_sel, run;
  logic [RATIO_LOG_W-1:0] ratio_lg;
  logic [LOG_W-1:0]       frame_lg;
  logic                   bclk_gen, fclk_gen;

  aclk_gen_ratio_dec #(.REV(REV)) dec_i (
    .mclk_code_i (mode_cfg_i[14:12]),
    .frame_code_i(mode_cfg_i[10:8]),
    .err_o       (cfg_err_o),
    .ratio_lg_o  (ratio_lg),
    .frame_lg_o  (frame_lg)
  );

  assign port_en    = clk_en_i[EN_BIT];
  assign master_sel = dir_i ? mode_cfg_i[4] : mode_cfg_i[0];
  assign run        = port_en & master_sel & ~cfg_err_o;

  aclk_gen_div div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .ratio_lg_i(ratio_lg),
    .frame_lg_i(frame_lg),
    .bclk_gen_o(bclk_gen),
    .fclk_gen_o(fclk_gen)
  );

  always_comb begin
    if (master_sel) begin
      bclk_o = bclk_gen ^ pol_cfg_i[8];
      fclk_o = fclk_gen ^ pol_cfg_i[12];
    end else begin
      bclk_o = ext_bclk_i ^ pol_cfg_i[0];
      fclk_o = ext_fclk_i ^ pol_cfg_i[4];
    end
  end

  a_r3_error_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err_o && master_sel) |-> (bclk_o == pol_cfg_i[8] && fclk_o == pol_cfg_i[12]));
endmodule

// File: tb/aclk_gen_tb.sv
module aclk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mode_cfg = '0;
  logic [15:0] pol_cfg = '0;
  logic [7:0]  clk_en = '0;
  logic        dir = 1'b0;
  logic        ext_b = 1'b0;
  logic        ext_f = 1'b0;
  logic        bclk, fclk, err;
  logic        bclk1, fclk1, err1;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  aclk_gen #(.REV(2), .PORT_IDX(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_cfg_i(mode_cfg), .pol_cfg_i(pol_cfg),
    .clk_en_i(clk_en), .dir_i(dir), .ext_bclk_i(ext_b), .ext_fclk_i(ext_f),
    .bclk_o(bclk), .fclk_o(fclk), .cfg_err_o(err));

  aclk_gen #(.REV(1), .PORT_IDX(0)) dut_r1 (
    .clk(clk), .rst_n(rst_n), .mode_cfg_i(mode_cfg), .pol_cfg_i(pol_cfg),
    .clk_en_i(clk_en), .dir_i(dir), .ext_bclk_i(ext_b), .ext_fclk_i(ext_f),
    .bclk_o(bclk1), .fclk_o(fclk1), .cfg_err_o(err1));

  function automatic int mpf(int code, int rev);
    case (code)
      0: return 512;
      1: return 256;
      2: return 128;
      3: return 64;
      4: return (rev >= 2) ? 32 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int bpf(int code, int rev);
    case (code)
      0: return 32;
      1: return 64;
      2: return 128;
      3: return 256;
      4: return 512;
      7: return (rev >= 2) ? 16 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_err(int m, int b);
    return (m == 0) || (b == 0) || (m < 2 * b);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // checks cycles 0..cyc-1 of master generation with ratio m/b
  task automatic run_gen(input int m, input int b, input int cyc, input string tag);
    int d;
    d = m / b;
    for (int n = 0; n < cyc; n++) begin
      chk({tag, " R4 bclk"}, bclk, (((n % d) >= d / 2) ? 1'b1 : 1'b0) ^ pol_cfg[8]);
      chk({tag, " R5 fclk"}, fclk, ((((n / d) % b) >= b / 2) ? 1'b1 : 1'b0) ^ pol_cfg[12]);
      step();
    end
  endtask

  initial begin
    #1_400_000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset state
    chk("reset R9 bclk", bclk, 1'b0);
    chk("reset R9 fclk", fclk, 1'b0);
    rst_n = 1'b1;
    step();

    // R1 R2 R3 R4 R5 R8: full code sweep
    for (int mc = 0; mc < 8; mc++) begin
      for (int bc = 0; bc < 8; bc++) begin
        int m2, b2, m1, b1;
        clk_en = 8'h00;
        step();
        m2 = mpf(mc, 2); b2 = bpf(bc, 2);
        m1 = mpf(mc, 1); b1 = bpf(bc, 1);
        mode_cfg = '0;
        mode_cfg[14:12] = 3'(mc);
        mode_cfg[10:8]  = 3'(bc);
        mode_cfg[0]     = 1'b1;
        pol_cfg = '0;
        pol_cfg[12] = mc[0];
        pol_cfg[8]  = bc[1];
        dir = 1'b0;
        clk_en = 8'h01;
        #1;
        chk("R1 R2 R3 err rev2", err, exp_err(m2, b2));
        chk("R1 R2 R3 err rev1", err1, exp_err(m1, b1));
        if (exp_err(m1, b1)) begin
          chk("R3 rev1 idle bclk", bclk1, pol_cfg[8]);
          chk("R3 rev1 idle fclk", fclk1, pol_cfg[12]);
        end
        if (exp_err(m2, b2)) begin
          for (int k = 0; k < 3; k++) begin
            chk("R3 idle bclk", bclk, pol_cfg[8]);
            chk("R3 idle fclk", fclk, pol_cfg[12]);
            step();
          end
        end else begin
          run_gen(m2, b2, 2 * m2 + 4, "sweep");
        end
      end
    end

    // R9: wrong enable bit ignored, idle level follows master inversion (R8)
    clk_en = 8'h00;
    step();
    mode_cfg = '0;
    mode_cfg[0] = 1'b1;  // 512 clocks, 32 bits: D=16
    pol_cfg = '0;
    pol_cfg[8] = 1'b1;
    pol_cfg[12] = 1'b1;
    clk_en = 8'hEE;
    for (int k = 0; k < 20; k++) begin
      chk("R9 other bits ignored bclk", bclk, 1'b1);
      chk("R9 other bits ignored fclk", fclk, 1'b1);
      step();
    end
    pol_cfg = '0;
    clk_en = 8'h01;
    #1;
    run_gen(512, 32, 77, "enable");
    // disable mid period: idle at once, then restart at phase zero (R10)
    clk_en = 8'h00;
    #1;
    chk("R9 disable bclk", bclk, 1'b0);
    chk("R9 disable fclk", fclk, 1'b0);
    step();
    chk("R9 disabled bclk", bclk, 1'b0);
    clk_en = 8'h01;
    #1;
    run_gen(512, 32, 40, "R10 restart");

    // R6 R7: input direction in slave mode while the output direction is master
    dir = 1'b1;
    pol_cfg = '0;
    pol_cfg[4] = 1'b1;
    for (int v = 0; v < 4; v++) begin
      ext_b = v[0];
      ext_f = v[1];
      #1;
      chk("R7 slave bclk", bclk, v[0]);
      chk("R7 slave fclk", fclk, ~v[1]);
      step();
    end
    clk_en = 8'h00;
    ext_b = 1'b1;
    #1;
    chk("R7 slave ignores enable", bclk, 1'b1);
    clk_en = 8'h01;
    step();
    // R6: bit 4 makes the input direction master; restarts at phase zero (R10)
    pol_cfg = '0;
    mode_cfg[4] = 1'b1;
    mode_cfg[0] = 1'b0;
    #1;
    run_gen(512, 32, 40, "R6 input master");
    // R6: output direction with only bit 4 set is slave
    dir = 1'b0;
    ext_b = 1'b0;
    ext_f = 1'b1;
    #1;
    chk("R6 out dir slave bclk", bclk, 1'b0);
    chk("R6 out dir slave fclk", fclk, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule